// File: doc/BRIEF.md
# Unlock Command Sequence Decoder

This block sits between the host write port of a byte-wide nonvolatile memory controller and its page buffer. It watches every write cycle (one address and one data byte per strobe) and looks for the multi-cycle unlock sequences. All commands share a two-cycle prefix. The third byte either finishes a short command or opens a longer six-cycle branch. When a sequence completes, the block emits a one-cycle command pulse. The commands are protected page-write arm, protection disable, chip erase, identification entry and identification exit.

The block keeps a sticky global write-protect flag and an identification-mode flag. A write that is not part of a command is a plain data write. It is forwarded to the page buffer as a pass pulse with its address and data. If protection is on and no arm window is open, it is refused with a reject pulse instead. While identification mode is on, a read-side address port returns the maker and device identifier bytes.

Top module: `ucsd_top`

## Requirements
- R1: After synchronous reset, every pulse output is 0, protect_on is 0 (protection starts disabled), id_mode is 0 and id_hit is 0.
- R2: The writes AAh@5555h, 55h@2AAAh, A0h@5555h raise arm_pulse for one cycle, registered on the edge of the third write. On that same edge protect_on becomes 1.
- R3: The prefix followed by 90h@5555h raises id_on_pulse and sets id_mode. The prefix followed by F0h@5555h raises id_off_pulse and clears id_mode.
- R4: The prefix, then 80h@5555h, AAh@5555h, 55h@2AAAh and a final byte at 5555h selects the command by that byte. 10h raises erase_pulse. 20h raises unprot_pulse and clears protect_on. 60h raises id_on_pulse and sets id_mode.
- R5: Only write address bits 14..0 are compared against the key addresses. Bits 16 and 15 have no effect on recognition.
- R6: A write that does not match the expected next address/data pair returns the decoder to idle. That same write is then evaluated as a first cycle: AAh@5555h starts a new prefix, and anything else is a plain data write.
- R7: A plain data write while protection is off gives pass_pulse one cycle later, with pass_addr and pass_data equal to the written address and byte. Writes consumed by a sequence give no pass_pulse.
- R8: A plain data write while protect_on is 1 and no arm window is open gives reject_pulse and no pass_pulse.
- R9: After an arm, plain writes pass as long as each write strobe comes within LOAD_TIMEOUT clock edges of the previous one. Once more than LOAD_TIMEOUT idle edges go by, the window closes and protected plain writes are rejected again.
- R10: While id_mode is 1 and rd_addr bits 14..1 are all zero, the next cycle shows id_hit=1 and id_data = BFh (bit 0 = 0) or 07h (bit 0 = 1). Otherwise id_hit=0 and id_data=00h.
- R11: At most one pulse output is high in any cycle, and a pulse only follows a cycle in which wr_stb was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One write cycle per high clock |
| wr_addr | input | 17 | Write address |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 15 | Read address, low bits, for identifier reads |
| arm_pulse | output | 1 | Protected page-write armed |
| unprot_pulse | output | 1 | Protection disable command |
| erase_pulse | output | 1 | Chip erase command |
| id_on_pulse | output | 1 | Identification entry command |
| id_off_pulse | output | 1 | Identification exit command |
| reject_pulse | output | 1 | Plain write refused by protection |
| pass_pulse | output | 1 | Plain write forwarded to page buffer |
| pass_addr | output | 17 | Address of forwarded write |
| pass_data | output | 8 | Data of forwarded write |
| protect_on | output | 1 | Global write-protect flag |
| id_mode | output | 1 | Identification mode flag |
| id_hit | output | 1 | Identifier read valid |
| id_data | output | 8 | Identifier byte |

## Verification
The bound checker watches, on every cycle, the invariants that hold whatever the stimulus. It checks that pulses are mutually exclusive and only follow a strobe, that each flag agrees with the pulse that changed it, and that protection rises only with an arm. It also checks that rejects and identifier hits only come out of the matching mode. Only the bench scenarios can show that the exact byte sequences are recognised, that the high address bits are ignored, and that an aborted sequence re-evaluates its breaking write. The same holds for the arm window closing after the idle gap, and for which identifier byte comes back for each address.

// File: rtl/ucsd_pkg.sv
package ucsd_pkg;
  localparam int KEY_W = 15;
  localparam logic [KEY_W-1:0] KEY_ADDR_A = 15'h5555;
  localparam logic [KEY_W-1:0] KEY_ADDR_B = 15'h2AAA;
  localparam logic [7:0] KEY_BYTE_A = 8'hAA;
  localparam logic [7:0] KEY_BYTE_B = 8'h55;
  localparam logic [7:0] OP_ARM     = 8'hA0;
  localparam logic [7:0] OP_IDON    = 8'h90;
  localparam logic [7:0] OP_IDOFF   = 8'hF0;
  localparam logic [7:0] OP_LONG    = 8'h80;
  localparam logic [7:0] OP_ERASE   = 8'h10;
  localparam logic [7:0] OP_UNPROT  = 8'h20;
  localparam logic [7:0] OP_IDON2   = 8'h60;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_P1, SQ_P2, SQ_X3, SQ_X4, SQ_X5
  } seq_t;

  typedef enum logic [2:0] {
    CMD_NONE, CMD_ARM, CMD_UNPROT, CMD_ERASE, CMD_IDON, CMD_IDOFF, CMD_PLAIN
  } cmd_t;
endpackage

// File: rtl/ucsd_seq_fsm.sv
module ucsd_seq_fsm
  import ucsd_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stb,
  input  logic [KEY_W-1:0]  addr,
  input  logic [DATA_W-1:0] data,
  output cmd_t              cmd
);
  seq_t state, nxt;
  logic hit_a, hit_b, at_a, miss;

  always_comb begin
    hit_a = (addr == KEY_ADDR_A) && (data == KEY_BYTE_A);
    hit_b = (addr == KEY_ADDR_B) && (data == KEY_BYTE_B);
    at_a  = (addr == KEY_ADDR_A);
    nxt   = state;
    cmd   = CMD_NONE;
    miss  = 1'b0;
    if (stb) begin
      case (state)
        SQ_P1: if (hit_b) nxt = SQ_P2; else miss = 1'b1;
        SQ_P2: begin
          nxt = SQ_IDLE;
          if (at_a && data == OP_ARM)        cmd = CMD_ARM;
          else if (at_a && data == OP_IDON)  cmd = CMD_IDON;
          else if (at_a && data == OP_IDOFF) cmd = CMD_IDOFF;
          else if (at_a && data == OP_LONG)  nxt = SQ_X3;
          else miss = 1'b1;
        end
        SQ_X3: if (hit_a) nxt = SQ_X4; else miss = 1'b1;
        SQ_X4: if (hit_b) nxt = SQ_X5; else miss = 1'b1;
        SQ_X5: begin
          nxt = SQ_IDLE;
          if (at_a && data == OP_ERASE)       cmd = CMD_ERASE;
          else if (at_a && data == OP_UNPROT) cmd = CMD_UNPROT;
          else if (at_a && data == OP_IDON2)  cmd = CMD_IDON;
          else miss = 1'b1;
        end
        default: miss = 1'b1;
      endcase
      if (miss) begin
        nxt = hit_a ? SQ_P1 : SQ_IDLE;
        cmd = hit_a ? CMD_NONE : CMD_PLAIN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= SQ_IDLE;
    else     state <= nxt;
  end
endmodule

// File: rtl/ucsd_mode_ctrl.sv
module ucsd_mode_ctrl
  import ucsd_pkg::*;
#(
  parameter int LOAD_TIMEOUT = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  cmd_t cmd,
  output logic protect_q,
  output logic armed_q,
  output logic idmode_q
);
  localparam int CNT_W = $clog2(LOAD_TIMEOUT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOAD_TIMEOUT - 1);
  logic [CNT_W-1:0] gap_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      protect_q <= 1'b0;
      armed_q   <= 1'b0;
      idmode_q  <= 1'b0;
      gap_cnt   <= '0;
    end else begin
      if (!armed_q || stb)          gap_cnt <= '0;
      else if (gap_cnt == CNT_LAST) armed_q <= 1'b0;
      else                          gap_cnt <= gap_cnt + 1'b1;
      if (stb) begin
        case (cmd)
          CMD_ARM:    begin protect_q <= 1'b1; armed_q <= 1'b1; end
          CMD_UNPROT: begin protect_q <= 1'b0; armed_q <= 1'b0; end
          CMD_IDON:   idmode_q <= 1'b1;
          CMD_IDOFF:  idmode_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ucsd_id_rom.sv
module ucsd_id_rom
  import ucsd_pkg::*;
#(
  parameter logic [7:0] MAKER_ID = 8'hBF,
  parameter logic [7:0] PART_ID  = 8'h07
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             idmode,
  input  logic [KEY_W-1:0] rd_addr,
  output logic             id_hit,
  output logic [7:0]       id_data
);
  logic sel;
  assign sel = idmode && (rd_addr[KEY_W-1:1] == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      id_hit  <= 1'b0;
      id_data <= 8'h00;
    end else begin
      id_hit  <= sel;
      id_data <= sel ? (rd_addr[0] ? PART_ID : MAKER_ID) : 8'h00;
    end
  end
endmodule

// File: rtl/ucsd_top.sv
module ucsd_top
  import ucsd_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int LOAD_TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [KEY_W-1:0]  rd_addr,
  output logic              arm_pulse,
  output logic              unprot_pulse,
  output logic              erase_pulse,
  output logic              id_on_pulse,
  output logic              id_off_pulse,
  output logic              reject_pulse,
  output logic              pass_pulse,
  output logic [ADDR_W-1:0] pass_addr,
  output logic [DATA_W-1:0] pass_data,
  output logic              protect_on,
  output logic              id_mode,
  output logic              id_hit,
  output logic [7:0]        id_data
);
  cmd_t cmd;
  logic armed, plain, blocked;

  ucsd_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst(rst), .stb(wr_stb),
    .addr(wr_addr[KEY_W-1:0]), .data(wr_data), .cmd(cmd)
  );

  ucsd_mode_ctrl #(.LOAD_TIMEOUT(LOAD_TIMEOUT)) u_mode (
    .clk(clk), .rst(rst), .stb(wr_stb), .cmd(cmd),
    .protect_q(protect_on), .armed_q(armed), .idmode_q(id_mode)
  );

  ucsd_id_rom u_id (
    .clk(clk), .rst(rst), .idmode(id_mode), .rd_addr(rd_addr),
    .id_hit(id_hit), .id_data(id_data)
  );

  assign plain   = wr_stb && (cmd == CMD_PLAIN);
  assign blocked = protect_on && !armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      arm_pulse    <= 1'b0;
      unprot_pulse <= 1'b0;
      erase_pulse  <= 1'b0;
      id_on_pulse  <= 1'b0;
      id_off_pulse <= 1'b0;
      reject_pulse <= 1'b0;
      pass_pulse   <= 1'b0;
      pass_addr    <= '0;
      pass_data    <= '0;
    end else begin
      arm_pulse    <= wr_stb && cmd == CMD_ARM;
      unprot_pulse <= wr_stb && cmd == CMD_UNPROT;
      erase_pulse  <= wr_stb && cmd == CMD_ERASE;
      id_on_pulse  <= wr_stb && cmd == CMD_IDON;
      id_off_pulse <= wr_stb && cmd == CMD_IDOFF;
      reject_pulse <= plain && blocked;
      pass_pulse   <= plain && !blocked;
      if (plain && !blocked) begin
        pass_addr <= wr_addr;
        pass_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/ucsd_chk.sv
module ucsd_chk (
  input logic clk,
  input logic rst,
  input logic wr_stb,
  input logic arm_pulse,
  input logic unprot_pulse,
  input logic erase_pulse,
  input logic id_on_pulse,
  input logic id_off_pulse,
  input logic reject_pulse,
  input logic pass_pulse,
  input logic protect_on,
  input logic id_mode,
  input logic id_hit
);
  logic [6:0] pv;
  assign pv = {arm_pulse, unprot_pulse, erase_pulse, id_on_pulse,
               id_off_pulse, reject_pulse, pass_pulse};

  // R11
  pulse_onehot_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(pv));
  // R11
  pulse_after_stb_chk: assert property (@(posedge clk) disable iff (rst) (|pv) |-> $past(wr_stb));
  // R2
  arm_sets_prot_chk: assert property (@(posedge clk) disable iff (rst) arm_pulse |-> protect_on);
  // R2
  prot_rise_chk: assert property (@(posedge clk) disable iff (rst) $rose(protect_on) |-> arm_pulse);
  // R4
  unprot_clears_chk: assert property (@(posedge clk) disable iff (rst) unprot_pulse |-> !protect_on);
  // R4
  prot_fall_chk: assert property (@(posedge clk) disable iff (rst) $fell(protect_on) |-> unprot_pulse);
  // R3
  id_on_chk: assert property (@(posedge clk) disable iff (rst) id_on_pulse |-> id_mode);
  // R3
  id_off_chk: assert property (@(posedge clk) disable iff (rst) id_off_pulse |-> !id_mode);
  // R8
  reject_prot_chk: assert property (@(posedge clk) disable iff (rst) reject_pulse |-> $past(protect_on));
  // R10
  id_hit_mode_chk: assert property (@(posedge clk) disable iff (rst) id_hit |-> $past(id_mode));
endmodule

bind ucsd_top ucsd_chk chk_i (
  .clk(clk), .rst(rst), .wr_stb(wr_stb),
  .arm_pulse(arm_pulse), .unprot_pulse(unprot_pulse), .erase_pulse(erase_pulse),
  .id_on_pulse(id_on_pulse), .id_off_pulse(id_off_pulse),
  .reject_pulse(reject_pulse), .pass_pulse(pass_pulse),
  .protect_on(protect_on), .id_mode(id_mode), .id_hit(id_hit)
);

// File: tb/ucsd_top_tb.sv
module ucsd_top_tb_top;
  localparam int CLK_P = 10;
  localparam int TMO   = 32;

  localparam logic [6:0] E_NONE = 7'b0000000;
  localparam logic [6:0] E_ARM  = 7'b1000000;
  localparam logic [6:0] E_UNP  = 7'b0100000;
  localparam logic [6:0] E_ERA  = 7'b0010000;
  localparam logic [6:0] E_ION  = 7'b0001000;
  localparam logic [6:0] E_IOFF = 7'b0000100;
  localparam logic [6:0] E_REJ  = 7'b0000010;
  localparam logic [6:0] E_PASS = 7'b0000001;

  typedef struct {
    logic [6:0]  pulses;
    logic [16:0] addr;
    logic [7:0]  data;
    logic        prot;
    logic        idm;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_stb = 1'b0;
  logic [16:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [14:0] rd_addr = '0;
  logic arm_pulse, unprot_pulse, erase_pulse, id_on_pulse, id_off_pulse;
  logic reject_pulse, pass_pulse, protect_on, id_mode, id_hit;
  logic [16:0] pass_addr;
  logic [7:0]  pass_data, id_data;

  int n_chk = 0;
  int n_err = 0;
  exp_t q[$];

  always #(CLK_P/2) clk = ~clk;

  ucsd_top #(.ADDR_W(17), .DATA_W(8), .LOAD_TIMEOUT(TMO)) dut_i (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .arm_pulse(arm_pulse), .unprot_pulse(unprot_pulse),
    .erase_pulse(erase_pulse), .id_on_pulse(id_on_pulse), .id_off_pulse(id_off_pulse),
    .reject_pulse(reject_pulse), .pass_pulse(pass_pulse), .pass_addr(pass_addr),
    .pass_data(pass_data), .protect_on(protect_on), .id_mode(id_mode),
    .id_hit(id_hit), .id_data(id_data)
  );

  function automatic logic [6:0] pulses_now();
    return {arm_pulse, unprot_pulse, erase_pulse, id_on_pulse,
            id_off_pulse, reject_pulse, pass_pulse};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // driver: one write cycle, expectation pushed to the scoreboard queue
  task automatic wr(input logic [16:0] a, input logic [7:0] d, input logic [6:0] p,
                    input logic prot, input logic idm, input string tag);
    exp_t e;
    @(negedge clk);
    e.pulses = p; e.addr = a; e.data = d; e.prot = prot; e.idm = idm; e.tag = tag;
    q.push_back(e);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [14:0] a, input logic hit, input logic [7:0] d, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(posedge clk);
    #1;
    check({tag, " id_hit"}, 32'(id_hit), 32'(hit));
    check({tag, " id_data"}, 32'(id_data), 32'(d));
  endtask

  // monitor: pop one expectation for every strobed edge
  always @(posedge clk) begin
    logic took;
    took = wr_stb && !rst;
    #1;
    if (took) begin
      if (q.size() == 0) begin
        check("scoreboard empty", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({e.tag, " pulses"}, 32'(pulses_now()), 32'(e.pulses));
        check({e.tag, " protect_on"}, 32'(protect_on), 32'(e.prot));
        check({e.tag, " id_mode"}, 32'(id_mode), 32'(e.idm));
        if (e.pulses == E_PASS) begin
          check({e.tag, " pass_addr"}, 32'(pass_addr), 32'(e.addr));
          check({e.tag, " pass_data"}, 32'(pass_data), 32'(e.data));
        end
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    check("watchdog expired", 32'd1, 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 pulses", 32'(pulses_now()), 32'(E_NONE));
    check("R1 protect_on", 32'(protect_on), 32'd0);
    check("R1 id_mode", 32'(id_mode), 32'd0);
    check("R1 id_hit", 32'(id_hit), 32'd0);

    // R7 plain write while unprotected
    wr(17'h00123, 8'h3C, E_PASS, 0, 0, "R7 plain");
    // R2 arm sequence; consumed writes give no pass (R7)
    wr(17'h05555, 8'hAA, E_NONE, 0, 0, "R7 consumed");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 0, "R7 consumed");
    wr(17'h05555, 8'hA0, E_ARM, 1, 0, "R2 arm");
    // R9 arm window
    wr(17'h00200, 8'h11, E_PASS, 1, 0, "R9 first load");
    idle(TMO - 2);
    wr(17'h00201, 8'h22, E_PASS, 1, 0, "R9 load within window");
    idle(TMO + 8);
    wr(17'h00202, 8'h33, E_REJ, 1, 0, "R9 window closed");
    wr(17'h00203, 8'h44, E_REJ, 1, 0, "R8 protected");

    // R6 restart on repeated first byte, then R3 id entry
    wr(17'h05555, 8'hAA, E_NONE, 1, 0, "R6 start");
    wr(17'h05555, 8'hAA, E_NONE, 1, 0, "R6 restart");
    wr(17'h02AAA, 8'h55, E_NONE, 1, 0, "R6 second");
    wr(17'h05555, 8'h90, E_ION, 1, 1, "R3 id entry");
    rd(15'h0000, 1, 8'hBF, "R10 maker");
    rd(15'h0001, 1, 8'h07, "R10 part");
    rd(15'h0002, 0, 8'h00, "R10 other addr");
    wr(17'h05555, 8'hAA, E_NONE, 1, 1, "R3 exit p1");
    wr(17'h02AAA, 8'h55, E_NONE, 1, 1, "R3 exit p2");
    wr(17'h05555, 8'hF0, E_IOFF, 1, 0, "R3 id exit");
    rd(15'h0000, 0, 8'h00, "R10 after exit");

    // R5 high address bits set; R4 protection disable
    wr(17'h1D555, 8'hAA, E_NONE, 1, 0, "R5 p1");
    wr(17'h0AAAA, 8'h55, E_NONE, 1, 0, "R5 p2");
    wr(17'h15555, 8'h80, E_NONE, 1, 0, "R5 long");
    wr(17'h05555, 8'hAA, E_NONE, 1, 0, "R4 x3");
    wr(17'h1AAAA, 8'h55, E_NONE, 1, 0, "R5 x4");
    wr(17'h05555, 8'h20, E_UNP, 0, 0, "R4 unprot");
    wr(17'h00300, 8'h5A, E_PASS, 0, 0, "R7 after unprot");

    // R4 erase
    wr(17'h05555, 8'hAA, E_NONE, 0, 0, "R4 e1");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 0, "R4 e2");
    wr(17'h05555, 8'h80, E_NONE, 0, 0, "R4 e3");
    wr(17'h05555, 8'hAA, E_NONE, 0, 0, "R4 e4");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 0, "R4 e5");
    wr(17'h05555, 8'h10, E_ERA, 0, 0, "R4 erase");

    // R4 alternate id entry
    wr(17'h05555, 8'hAA, E_NONE, 0, 0, "R4 i1");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 0, "R4 i2");
    wr(17'h05555, 8'h80, E_NONE, 0, 0, "R4 i3");
    wr(17'h05555, 8'hAA, E_NONE, 0, 0, "R4 i4");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 0, "R4 i5");
    wr(17'h05555, 8'h60, E_ION, 0, 1, "R4 alt id entry");
    rd(15'h0001, 1, 8'h07, "R10 alt part");
    wr(17'h05555, 8'hAA, E_NONE, 0, 1, "R3 x1");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 1, "R3 x2");
    wr(17'h05555, 8'hF0, E_IOFF, 0, 0, "R3 exit again");

    // R6 abort in long branch: breaking write becomes plain, then idle decode
    wr(17'h05555, 8'hAA, E_NONE, 0, 0, "R6 a1");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 0, "R6 a2");
    wr(17'h05555, 8'h80, E_NONE, 0, 0, "R6 a3");
    wr(17'h01234, 8'h77, E_PASS, 0, 0, "R6 break");
    wr(17'h05555, 8'h10, E_PASS, 0, 0, "R6 idle final byte");
    // R6 wrong third byte
    wr(17'h05555, 8'hAA, E_NONE, 0, 0, "R6 b1");
    wr(17'h02AAA, 8'h55, E_NONE, 0, 0, "R6 b2");
    wr(17'h05555, 8'h33, E_PASS, 0, 0, "R6 bad op");

    idle(4);
    check("R11 scoreboard drained", 32'(q.size()), 32'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule